// File: doc/BRIEF.md
# MDIO Management Master with Register Control

This block is the management-interface master that a network controller uses to reach the configuration registers of external PHYs over a two-wire serial link: a clock line (MDC) and a bidirectional data line (MDIO). Software fills one 32-bit command word with an opcode, a PHY address, a PHY register address and, for writes, a 16-bit value, and sets the go/busy bit in the same write. The block then shifts out one clause-22 frame and clears the go/busy bit by itself when the frame ends.

A second word holds the configuration: a 6-bit MDC divider, a preamble-suppress flag and a clause-22 select bit. MDC runs only while a frame is in progress, with a period of 2×(divider+1) system clocks. The data line is presented as a separate output value and output enable, so the pad and its pull-up stay outside the block. On a read, the block releases the line from the turnaround onward. It records a failure if the PHY leaves the second turnaround bit high, and it collects the 16 returned bits into the data field of the command word.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command word (offset 0x0) reads 0x00000000 and the configuration word (offset 0x4) reads 0x000003F1: divider 0x3F, clause-22 bit set, preamble suppression clear. MDC is low and the output enable is low.
- R2: The command word layout is: bit 29 go/busy, bit 28 read-fail, bits 27:26 opcode, bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data. A command write with bit 29 clear stores the fields and starts nothing.
- R3: A command write with bit 29 set, made while idle, starts a frame. Bit 29 reads 1 from the next cycle for exactly N×2×(D+1) cycles, then reads 0. N is 64 bits with preamble or 32 without, and D is the divider.
- R4: MDC is low while idle. During a frame it stays low for D+1 cycles, then high for D+1 cycles, and repeats.
- R5: With preamble enabled, the frame carries these bits in order, each field MSB first: 32 ones, start 01, the two opcode bits, the 5 PHY address bits, the 5 register address bits, 2 turnaround bits, and 16 data bits.
- R6: With preamble suppression set (configuration bit 12), the 32 ones are omitted and the frame starts with the start pattern.
- R7: Opcode 1 is a write. The output enable is high for the whole frame, the turnaround is sent as 1 then 0, and the data field of the command word follows.
- R8: Opcode 2 is a read. The output enable drops for the turnaround and the data bits. The 16 bits sampled on the MDC rising edges of the data phase appear in bits 15:0 of the command word, first sampled bit in bit 15.
- R9: On a read, if the line is high at the rising MDC edge of the second turnaround bit, bit 28 is set. Bit 28 is cleared when the next frame starts.
- R10: A write to the command word while bit 29 is set has no effect: the frame in flight and the stored fields do not change.
- R11: The configuration word (offset 0x4) holds bit 0 clause-22 select, bits 9:4 divider and bit 12 preamble suppression, and reads back what was written in those bits. All other bits read 0.
- R12: The output value changes only on MDC falling edges (or at frame start). It is stable while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line value when driven |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line as seen at the pad |

## Verification
The assertions assume that the PHY side only changes `mdio_i` while the master has released the line, and that the configuration word is not rewritten while a frame is in flight. The bench stays inside these limits. A behavioural PHY model drives `mdio_i` with the master's own value whenever the enable is high, and otherwise drives the turnaround and data bits, changing them only at bit boundaries so that every rising MDC edge sees a settled value. Configuration writes are issued only between frames. The single command write made during a frame aims at the busy lockout.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int CSR_DW      = 32;
    localparam int CSR_AW      = 4;
    localparam int DIV_W       = 6;
    localparam int PHY_AW      = 5;
    localparam int REG_AW      = 5;
    localparam int VAL_W       = 16;
    localparam int PRE_LEN     = 32;
    localparam int PAYLOAD_LEN = 2 + 2 + PHY_AW + REG_AW + 2 + VAL_W;
    localparam int FRAME_LEN   = PRE_LEN + PAYLOAD_LEN;
    localparam int FRAME_BW    = $clog2(FRAME_LEN);

    // payload positions the sequencer decodes
    localparam int TA_POS      = 2 + 2 + PHY_AW + REG_AW;
    localparam int TA2_POS     = TA_POS + 1;
    localparam int DATA_POS    = TA_POS + 2;

    // register offsets
    localparam logic [CSR_AW-1:0] OFS_CMD = 4'h0;
    localparam logic [CSR_AW-1:0] OFS_CFG = 4'h4;

    // command word bit positions
    localparam int GO_BIT   = 29;
    localparam int FAIL_BIT = 28;
    localparam int OP_LSB   = 26;
    localparam int PHY_LSB  = 21;
    localparam int REG_LSB  = 16;

    // configuration word bit positions
    localparam int C22_BIT  = 0;
    localparam int DIV_LSB  = 4;
    localparam int NOPRE_BIT = 12;

    typedef enum logic [1:0] {
        OP_RSV0  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RSV3  = 2'd3
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e            op;
        logic [PHY_AW-1:0]   phy;
        logic [REG_AW-1:0]   regad;
        logic [VAL_W-1:0]    value;
    } mdio_cmd_t;

    typedef struct packed {
        logic                no_pre;
        logic [DIV_W-1:0]    div;
        logic                c22;
    } mdio_cfg_t;

    function automatic mdio_cmd_t unpack_cmd(input logic [CSR_DW-1:0] w);
        mdio_cmd_t c;
        c.op    = mdio_op_e'(w[OP_LSB +: 2]);
        c.phy   = w[PHY_LSB +: PHY_AW];
        c.regad = w[REG_LSB +: REG_AW];
        c.value = w[0 +: VAL_W];
        return c;
    endfunction

    function automatic logic [CSR_DW-1:0] pack_cmd(input logic busy,
                                                   input logic fail,
                                                   input mdio_cmd_t c);
        logic [CSR_DW-1:0] w;
        w = '0;
        w[GO_BIT]             = busy;
        w[FAIL_BIT]           = fail;
        w[OP_LSB +: 2]        = c.op;
        w[PHY_LSB +: PHY_AW]  = c.phy;
        w[REG_LSB +: REG_AW]  = c.regad;
        w[0 +: VAL_W]         = c.value;
        return w;
    endfunction

    function automatic logic [CSR_DW-1:0] pack_cfg(input mdio_cfg_t f);
        logic [CSR_DW-1:0] w;
        w = '0;
        w[C22_BIT]            = f.c22;
        w[DIV_LSB +: DIV_W]   = f.div;
        w[NOPRE_BIT]          = f.no_pre;
        return w;
    endfunction

    // serial payload after the preamble, first bit in the MSB
    function automatic logic [PAYLOAD_LEN-1:0] build_payload(input mdio_cmd_t c);
        logic [1:0] ta;
        ta = (c.op == OP_READ) ? 2'b11 : 2'b10;
        return {2'b01, c.op, c.phy, c.regad, ta, c.value};
    endfunction

endpackage

// File: rtl/mdio_csr.sv
module mdio_csr
    import mdio_mgmt_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RESET = 6'h3F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    input  logic              busy,
    input  logic              fail_set,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic              start,
    output mdio_cmd_t         launch,
    output mdio_cmd_t         cmd_q,
    output logic              fail_q,
    output mdio_cfg_t         cfg_q
);

    logic wr_cmd;
    logic wr_cfg;
    logic unused_wbits;

    assign wr_cmd = csr_wr && (csr_addr == OFS_CMD);
    assign wr_cfg = csr_wr && (csr_addr == OFS_CFG);
    assign launch = unpack_cmd(csr_wdata);
    assign start  = wr_cmd && !busy && csr_wdata[GO_BIT];
    assign unused_wbits = ^{csr_wdata[31:30], csr_wdata[FAIL_BIT]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (wr_cmd && !busy) begin
            cmd_q <= launch;
        end else if (shift_en) begin
            cmd_q.value <= {cmd_q.value[VAL_W-2:0], shift_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fail_q <= 1'b0;
        end else if (start) begin
            fail_q <= 1'b0;
        end else if (fail_set) begin
            fail_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.c22    <= 1'b1;
            cfg_q.div    <= DIV_RESET;
            cfg_q.no_pre <= 1'b0;
        end else if (wr_cfg) begin
            cfg_q.c22    <= csr_wdata[C22_BIT];
            cfg_q.div    <= csr_wdata[DIV_LSB +: DIV_W];
            cfg_q.no_pre <= csr_wdata[NOPRE_BIT];
        end
    end

    always_comb begin
        case (csr_addr)
            OFS_CMD: csr_rdata = pack_cmd(busy, fail_q, cmd_q);
            OFS_CFG: csr_rdata = pack_cfg(cfg_q);
            default: csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_mgmt_pkg::*;
#(
    parameter int CNT_W = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap      = run && (cnt_q == div);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_mgmt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  mdio_cmd_t launch,
    input  logic      no_pre,
    input  logic      rise_tick,
    input  logic      fall_tick,
    input  logic      mdio_i,
    output logic      busy,
    output logic      mdio_o,
    output logic      mdio_oe,
    output logic      fail_set,
    output logic      shift_en,
    output logic      shift_bit
);

    localparam logic [FRAME_BW-1:0] PRE_START = FRAME_BW'(PRE_LEN);
    localparam logic [FRAME_BW-1:0] LAST_BIT  = FRAME_BW'(FRAME_LEN - 1);

    logic [FRAME_BW-1:0]    bitcnt_q;
    logic [PAYLOAD_LEN-1:0] shreg_q;
    logic                   rd_q;
    logic                   in_payload;
    logic [FRAME_BW-1:0]    pos;
    logic                   released;

    assign in_payload = (bitcnt_q >= PRE_START);
    assign pos        = bitcnt_q - PRE_START;
    assign released   = rd_q && in_payload && (pos >= FRAME_BW'(TA_POS));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            bitcnt_q <= '0;
            shreg_q  <= '0;
            rd_q     <= 1'b0;
        end else if (start) begin
            busy     <= 1'b1;
            bitcnt_q <= no_pre ? PRE_START : '0;
            shreg_q  <= build_payload(launch);
            rd_q     <= (launch.op == OP_READ);
        end else if (busy && fall_tick) begin
            if (bitcnt_q == LAST_BIT) begin
                busy     <= 1'b0;
                bitcnt_q <= '0;
            end else begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end
            if (in_payload) begin
                shreg_q <= {shreg_q[PAYLOAD_LEN-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        if (!busy) begin
            mdio_o = 1'b1;
        end else if (!in_payload) begin
            mdio_o = 1'b1;
        end else begin
            mdio_o = shreg_q[PAYLOAD_LEN-1];
        end
    end

    assign mdio_oe   = busy && !released;
    assign fail_set  = busy && rise_tick && rd_q && in_payload
                       && (pos == FRAME_BW'(TA2_POS)) && mdio_i;
    assign shift_en  = busy && rise_tick && rd_q && in_payload
                       && (pos >= FRAME_BW'(DATA_POS));
    assign shift_bit = mdio_i;

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter logic [DIV_W-1:0] DIV_RESET = 6'h3F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr,
    input  logic [CSR_AW-1:0] csr_addr,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic      busy;
    logic      start;
    logic      fail_set;
    logic      fail_q;
    logic      shift_en;
    logic      shift_bit;
    logic      rise_tick;
    logic      fall_tick;
    mdio_cmd_t launch;
    mdio_cmd_t cmd_q;
    mdio_cfg_t cfg_q;

    mdio_csr #(.DIV_RESET(DIV_RESET)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .csr_wr    (csr_wr),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .busy      (busy),
        .fail_set  (fail_set),
        .shift_en  (shift_en),
        .shift_bit (shift_bit),
        .start     (start),
        .launch    (launch),
        .cmd_q     (cmd_q),
        .fail_q    (fail_q),
        .cfg_q     (cfg_q)
    );

    mdio_mdc_gen #(.CNT_W(DIV_W)) u_mdc (
        .clk       (clk),
        .rst       (rst),
        .run       (busy),
        .div       (cfg_q.div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .launch    (launch),
        .no_pre    (cfg_q.no_pre),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .busy      (busy),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .fail_set  (fail_set),
        .shift_en  (shift_en),
        .shift_bit (shift_bit)
    );

endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk
    import mdio_mgmt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              csr_wr,
    input logic [CSR_AW-1:0] csr_addr,
    input logic              busy,
    input logic              mdc,
    input logic              mdio_o,
    input logic              mdio_oe,
    input logic              fail_q,
    input mdio_cmd_t         cmd_q,
    input logic              rd_q,
    input logic [FRAME_BW-1:0] bitcnt
);

    // R4: clock parked low and line released between frames
    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    // R12: driven value does not move while MDC is high
    p_hold_while_high_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && mdc && $past(mdc) && $past(busy)) |-> $stable(mdio_o));

    // R10: command fields frozen while a frame is in flight
    p_busy_lock_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && csr_wr && csr_addr == OFS_CMD) |=>
            ($stable(cmd_q.op) && $stable(cmd_q.phy) && $stable(cmd_q.regad)));

    // R9: fail flag is clear as a frame begins
    p_fail_clear_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !fail_q);

    // R8: line released during read turnaround and data
    p_read_release_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_q && bitcnt >= FRAME_BW'(PRE_LEN + TA_POS)) |-> !mdio_oe);

    // R7: writes keep the line driven throughout
    p_write_drive_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && !rd_q) |-> mdio_oe);

endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .csr_wr   (csr_wr),
    .csr_addr (csr_addr),
    .busy     (busy),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .fail_q   (fail_q),
    .cmd_q    (cmd_q),
    .rd_q     (u_seq.rd_q),
    .bitcnt   (u_seq.bitcnt_q)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr = 1'b0;
    logic [3:0]  csr_addr = 4'h0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mdc;
    logic        mdio_o;
    logic        mdio_oe;
    logic        mdio_i;
    logic        phy_drive = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cur_div = 63;
    bit cur_nopre = 1'b0;

    always #10 clk = ~clk;

    // pad: master value when enabled, otherwise the PHY model
    assign mdio_i = mdio_oe ? mdio_o : phy_drive;

    mdio_mgmt_master u_mdio_mgmt_master (
        .clk       (clk),
        .rst       (rst),
        .csr_wr    (csr_wr),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_i)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        csr_addr  = a;
        csr_wdata = d;
        csr_wr    = 1'b1;
        @(negedge clk);
        csr_wr    = 1'b0;
        csr_addr  = 4'h0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
        csr_addr = 4'h0;
        #1;
    endtask

    function automatic logic [31:0] cmd_word(input bit go, input bit fl,
                                             input logic [1:0] op,
                                             input logic [4:0] phy,
                                             input logic [4:0] rg,
                                             input logic [15:0] v);
        return {2'b00, go, fl, op, phy, rg, v};
    endfunction

    task automatic set_cfg(input bit nopre, input int dv, input bit c22);
        logic [31:0] rb;
        logic [31:0] exp;
        exp = 32'(nopre) << 12 | 32'(dv) << 4 | 32'(c22);
        reg_write(4'h4, exp | 32'hFFFF_E00E);
        reg_read(4'h4, rb);
        chk(rb == exp, "R11 cfg readback", rb, exp);
        cur_div   = dv;
        cur_nopre = nopre;
    endtask

    // Launch one frame and compare the ports on every clock until it ends.
    task automatic run_frame(input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] wv,
                             input logic [15:0] resp, input bit ta_ok,
                             input int inj, input string tag);
        int  half;
        int  bits;
        int  total;
        bit  rd;
        logic [31:0] pl;
        logic [31:0] rb;
        logic [31:0] exp;
        half  = cur_div + 1;
        bits  = cur_nopre ? 32 : 64;
        total = bits * 2 * half;
        rd    = (op == 2'd2);
        pl    = {2'b01, op, phy, rg, 2'b10, wv};
        reg_write(4'h0, cmd_word(1'b1, 1'b0, op, phy, rg, wv));
        for (int k = 0; k <= total; k++) begin
            int  b;
            int  pos;
            bit  exp_busy;
            bit  exp_mdc;
            bit  exp_oe;
            bit  exp_bit;
            exp_busy = (k < total);
            exp_mdc  = exp_busy ? ((k / half) % 2 == 1) : 1'b0;
            b   = k / (2 * half) + (cur_nopre ? 32 : 0);
            pos = b - 32;
            exp_oe  = exp_busy && !(rd && b >= 32 && pos >= 14);
            exp_bit = (b < 32) ? 1'b1 : pl[31 - ((pos < 32) ? pos : 0)];
            chk(csr_rdata[29] == exp_busy, {tag, " R3 busy"}, 32'(csr_rdata[29]), 32'(exp_busy));
            chk(mdc == exp_mdc, {tag, " R4 mdc"}, 32'(mdc), 32'(exp_mdc));
            chk(mdio_oe == exp_oe, {tag, " R7/R8 oe"}, 32'(mdio_oe), 32'(exp_oe));
            if (exp_oe) begin
                chk(mdio_o == exp_bit, {tag, " R5/R12 bit"}, 32'(b), 32'(exp_bit));
            end
            // PHY side
            if (exp_busy && rd && b >= 32 && pos == 15) phy_drive = !ta_ok;
            else if (exp_busy && rd && b >= 32 && pos >= 16) phy_drive = resp[31 - pos];
            else phy_drive = 1'b1;
            if (k == inj) begin
                csr_wdata = cmd_word(1'b1, 1'b0, 2'd2, 5'h1F, 5'h1F, 16'hFFFF);
                csr_wr    = 1'b1;
            end else begin
                csr_wr    = 1'b0;
            end
            if (k < total) @(negedge clk);
        end
        csr_wr = 1'b0;
        phy_drive = 1'b1;
        reg_read(4'h0, rb);
        exp = cmd_word(1'b0, rd && !ta_ok, op, phy, rg, rd ? resp : wv);
        chk(rb == exp, {tag, " R2/R8/R9/R10 cmd readback"}, rb, exp);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] rb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        reg_read(4'h0, rb);
        chk(rb == 32'h0, "R1 cmd reset", rb, 32'h0);
        reg_read(4'h4, rb);
        chk(rb == 32'h0000_03F1, "R1 cfg reset", rb, 32'h0000_03F1);
        chk(mdc == 1'b0, "R1 mdc reset", 32'(mdc), 0);
        chk(mdio_oe == 1'b0, "R1 oe reset", 32'(mdio_oe), 0);
        @(negedge clk);

        // R5 R7: write at the reset divider, full preamble
        run_frame(2'd1, 5'h05, 5'h11, 16'hBEEF, 16'h0, 1'b1, -1, "default-div write");

        // R2: fields stored without launching
        reg_write(4'h0, cmd_word(1'b0, 1'b1, 2'd2, 5'h0A, 5'h03, 16'h1357));
        for (int i = 0; i < 6; i++) begin
            chk(csr_rdata[29] == 1'b0 && mdc == 1'b0, "R2 no launch", {csr_rdata[29], mdc}, 0);
            @(negedge clk);
        end
        reg_read(4'h0, rb);
        chk(rb == cmd_word(1'b0, 1'b0, 2'd2, 5'h0A, 5'h03, 16'h1357), "R2 fields",
            rb, cmd_word(1'b0, 1'b0, 2'd2, 5'h0A, 5'h03, 16'h1357));

        // R11 R4: small divider write
        set_cfg(1'b0, 1, 1'b1);
        run_frame(2'd1, 5'h12, 5'h07, 16'h5A0F, 16'h0, 1'b1, -1, "div1 write");

        // R8: read with good turnaround, divider 0
        set_cfg(1'b0, 0, 1'b1);
        run_frame(2'd2, 5'h01, 5'h02, 16'h0000, 16'hA5C3, 1'b1, -1, "read ok");

        // R6 R9: suppressed preamble, PHY leaves turnaround high
        set_cfg(1'b1, 2, 1'b0);
        run_frame(2'd2, 5'h1F, 5'h1E, 16'h0000, 16'h1234, 1'b0, -1, "read fail nopre");

        // R9: next start clears the fail flag
        run_frame(2'd2, 5'h03, 5'h04, 16'h0000, 16'h8001, 1'b1, -1, "read clears fail");

        // R10: command write mid-frame is ignored
        set_cfg(1'b0, 0, 1'b1);
        run_frame(2'd1, 5'h09, 5'h0C, 16'hC0DE, 16'h0, 1'b1, 10, "busy write ignored");

        // R6: suppressed-preamble write
        set_cfg(1'b1, 1, 1'b1);
        run_frame(2'd1, 5'h10, 5'h01, 16'h0F0F, 16'h0, 1'b1, -1, "nopre write");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule